// File: doc/BRIEF.md
# Ancillary Packet Checksum Checker and Inserter

This block sits in a stream of 10-bit component video words and finds ancillary data packets in it. Each packet starts with the three-word flag 000h, 3FFh, 3FFh. A data identifier word, a secondary identifier or block number word and a data-count word follow, then the user-data words, then one checksum word. The block sums the identifier, count and user-data words and handles the word in the checksum slot in one of two ways. It can check that word against the computed value, or it can overwrite the word with the computed value.

Two control inputs pick the behaviour. `attachIn` says whether the incoming packets already carry a valid checksum. `forceFix` says what to do when a carried checksum turns out to be wrong: rewrite it in the stream, or pass it through and raise the sticky `sumErr` output. Every word, inside or outside a packet, leaves the block exactly one clock after it enters.

Top module: `anc_sum_top`

## Requirements
- R1: Each accepted input word (inValid=1) appears on outWord with outValid=1 exactly one clock later. outValid is 0 in the cycle after a cycle with inValid=0.
- R2: Words outside ancillary packets, and the flag, identifier, count and user-data words of a packet, pass through unchanged.
- R3: A packet is recognised only after the consecutive accepted words 000h, 3FFh, 3FFh. A broken flag such as 000h, 3FFh, 100h starts no packet. Repeated 000h words before 3FFh, 3FFh still allow detection.
- R4: The computed checksum word has bits 8:0 equal to the sum, modulo 512, of bits 8:0 of every word from the data identifier through the last user-data word. Its bit 9 is the inverse of its bit 8.
- R5: The number of user-data words equals bits 7:0 of the data-count word, and bits 9:8 are ignored. A count of 0 puts the checksum word directly after the count word.
- R6: With attachIn=0, the word in the checksum slot is replaced by the computed checksum word, and sumErr is not set.
- R7: With attachIn=1 and a received checksum equal to the computed one, the word passes unchanged and sumErr is not set.
- R8: With attachIn=1, a mismatch and forceFix=1, the computed checksum replaces the received word and sumErr is not set.
- R9: With attachIn=1, a mismatch and forceFix=0, the received word passes unchanged and sumErr becomes 1 in the same cycle that the checksum word is output.
- R10: sumErr stays 1 until errClear is sampled high or reset is applied. If a new error and a clear arrive in the same cycle, the error wins.
- R11: After reset, outValid=0, outWord=000h and sumErr=0.
- R12: Cycles with inValid=0 advance no packet parsing and leave outWord unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inWord | input | 10 | Incoming video word |
| inValid | input | 1 | inWord is valid this cycle |
| attachIn | input | 1 | 1: packets carry a checksum to check; 0: generate the checksum |
| forceFix | input | 1 | 1: overwrite a mismatching received checksum |
| errClear | input | 1 | Clears the sticky checksum-error flag |
| outWord | output | 10 | Outgoing video word, one cycle later |
| outValid | output | 1 | outWord is valid |
| sumErr | output | 1 | Sticky checksum-mismatch flag |

## Verification
The hardest case to reach is a mismatch whose handling hangs on two control bits together. It can only happen at the one word position that the header's count points to, after a correct flag sequence. The bench builds whole packets from a reference checksum function. It then corrupts or keeps the checksum word and runs every packet under all four settings of attachIn and forceFix. Idle gaps inside a packet, a count word with its upper bits set and a zero count move that checksum position, so the bench covers these too.

// File: rtl/anc_sum_pkg.sv
package anc_sum_pkg;
  // strobes from the parser to the datapath
  typedef struct packed {
    logic sumLoad;   // start a new sum with this word
    logic sumAdd;    // add this word to the sum
    logic useCalc;   // put the computed checksum on the output
    logic raiseErr;  // flag a checksum mismatch
  } strobe_t;

  typedef enum logic [2:0] {
    SEEK0, SEEK1, SEEK2, GET_DID, GET_SDID, GET_DC, GET_UDW, GET_SUM
  } pstate_t;
endpackage

// File: rtl/anc_sum_ctrl.sv
module anc_sum_ctrl
  import anc_sum_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  input  logic              attachIn,
  input  logic              forceFix,
  input  logic              sumMatch,
  output strobe_t           stb
);
  localparam int CNT_W = WORD_W - 2;
  localparam logic [WORD_W-1:0] FLAG_LO = '0;
  localparam logic [WORD_W-1:0] FLAG_HI = '1;

  pstate_t state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    cntNxt   = cnt;
    if (inValid) begin
      case (state)
        SEEK0: if (inWord == FLAG_LO) stateNxt = SEEK1;
        SEEK1: begin
          if (inWord == FLAG_HI)      stateNxt = SEEK2;
          else if (inWord == FLAG_LO) stateNxt = SEEK1;
          else                        stateNxt = SEEK0;
        end
        SEEK2: begin
          if (inWord == FLAG_HI)      stateNxt = GET_DID;
          else if (inWord == FLAG_LO) stateNxt = SEEK1;
          else                        stateNxt = SEEK0;
        end
        GET_DID: begin
          stb.sumLoad = 1'b1;
          stateNxt    = GET_SDID;
        end
        GET_SDID: begin
          stb.sumAdd = 1'b1;
          stateNxt   = GET_DC;
        end
        GET_DC: begin
          stb.sumAdd = 1'b1;
          cntNxt     = inWord[CNT_W-1:0];
          stateNxt   = (inWord[CNT_W-1:0] == '0) ? GET_SUM : GET_UDW;
        end
        GET_UDW: begin
          stb.sumAdd = 1'b1;
          cntNxt     = cnt - 1'b1;
          stateNxt   = (cnt == CNT_W'(1)) ? GET_SUM : GET_UDW;
        end
        GET_SUM: begin
          stateNxt = SEEK0;
          if (!attachIn)       stb.useCalc  = 1'b1;
          else if (!sumMatch) begin
            if (forceFix)      stb.useCalc  = 1'b1;
            else               stb.raiseErr = 1'b1;
          end
        end
        default: stateNxt = SEEK0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SEEK0;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  AST_UDW_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    state == GET_UDW |-> cnt != '0);  // R5
  AST_SUM_ENDS_PACKET: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && state == GET_SUM) |=> state == SEEK0);  // R3
  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(state));  // R12
endmodule

// File: rtl/anc_sum_path.sv
module anc_sum_path
  import anc_sum_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  input  logic              errClear,
  input  strobe_t           stb,
  output logic              sumMatch,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid,
  output logic              sumErr
);
  localparam int SUM_W = WORD_W - 1;

  logic [SUM_W-1:0]  sum;
  logic [WORD_W-1:0] calcWord;

  assign calcWord = {~sum[SUM_W-1], sum};
  assign sumMatch = (inWord == calcWord);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sum      <= '0;
      outWord  <= '0;
      outValid <= 1'b0;
      sumErr   <= 1'b0;
    end else begin
      if (stb.sumLoad)     sum <= inWord[SUM_W-1:0];
      else if (stb.sumAdd) sum <= sum + inWord[SUM_W-1:0];
      outValid <= inValid;
      if (inValid) outWord <= stb.useCalc ? calcWord : inWord;
      if (stb.raiseErr)    sumErr <= 1'b1;
      else if (errClear)   sumErr <= 1'b0;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R1
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outWord)));  // R12
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (sumErr && !errClear) |=> sumErr);  // R10
  AST_INSERT_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && stb.useCalc) |=> outWord[WORD_W-1] != outWord[WORD_W-2]);  // R4
  AST_ERR_NEEDS_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    stb.raiseErr |-> !sumMatch);  // R9
endmodule

// File: rtl/anc_sum_top.sv
module anc_sum_top
  import anc_sum_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  input  logic              attachIn,
  input  logic              forceFix,
  input  logic              errClear,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid,
  output logic              sumErr
);
  strobe_t stb;
  logic    sumMatch;

  anc_sum_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inValid(inValid),
    .attachIn(attachIn), .forceFix(forceFix), .sumMatch(sumMatch), .stb(stb)
  );

  anc_sum_path #(.WORD_W(WORD_W)) u_path (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inValid(inValid),
    .errClear(errClear), .stb(stb), .sumMatch(sumMatch),
    .outWord(outWord), .outValid(outValid), .sumErr(sumErr)
  );
endmodule

// File: tb/anc_sum_top_tb.sv
module anc_sum_top_tb;
  logic       clk = 0;
  logic       rstN = 0;
  logic [9:0] inWord = '0;
  logic       inValid = 0, attachIn = 0, forceFix = 0, errClear = 0;
  logic [9:0] outWord;
  logic       outValid, sumErr;
  int nChecks = 0, nFails = 0;
  logic [8:0] refSum;

  always #4 clk = ~clk;  // 125 MHz

  anc_sum_top u_dut (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inValid(inValid),
    .attachIn(attachIn), .forceFix(forceFix), .errClear(errClear),
    .outWord(outWord), .outValid(outValid), .sumErr(sumErr)
  );

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] mkSum(input logic [8:0] s);
    return {~s[8], s};
  endfunction

  // drive one word mid-cycle, check its output one clock later
  task automatic sendWord(input logic [9:0] w, input logic [9:0] exp, input string tag);
    inWord = w; inValid = 1;
    @(posedge clk); #2;
    check({tag, " outValid"}, {9'd0, outValid}, 10'd1);
    check(tag, outWord, exp);
    inValid = 0;
  endtask

  task automatic idle(input string tag);
    logic [9:0] prev;
    prev = outWord;
    inValid = 0; inWord = 10'h2AA;
    @(posedge clk); #2;
    check({tag, " gap outValid"}, {9'd0, outValid}, 10'd0);
    check({tag, " gap outWord"}, outWord, prev);
  endtask

  task automatic sendFlag(input string tag);
    sendWord(10'h000, 10'h000, tag);
    sendWord(10'h3FF, 10'h3FF, tag);
    sendWord(10'h3FF, 10'h3FF, tag);
  endtask

  // header+data; accumulates refSum; optional gap in the middle
  task automatic sendBody(input logic [9:0] did, input logic [9:0] dc, input int seed,
                          input bit gap, input string tag);
    logic [9:0] w;
    sendWord(did, did, {tag, " R2 did"});
    refSum = did[8:0];
    w = 10'h140 + 10'(seed);
    sendWord(w, w, {tag, " R2 sdid"});
    refSum += w[8:0];
    if (gap) idle({tag, " R12"});
    sendWord(dc, dc, {tag, " R2 dc"});
    refSum += dc[8:0];
    for (int k = 0; k < int'(dc[7:0]); k++) begin
      w = 10'((seed * 91 + k * 37 + 5) & 10'h3FF);
      if (w == 10'h000 || w == 10'h3FF) w = 10'h155;
      sendWord(w, w, {tag, " R2 udw"});
      refSum += w[8:0];
      if (gap && k == 0) idle({tag, " R12"});
    end
  endtask

  // full packet; bad=1 corrupts the carried checksum
  task automatic packetCase(input bit att, input bit frc, input bit bad, input int seed,
                            input string tag);
    logic [9:0] good, sent, exp;
    bit expErr;
    attachIn = att; forceFix = frc;
    sendFlag({tag, " R3 flag"});
    sendBody(10'h045 + 10'(seed), 10'd3 + 10'(seed % 3), seed, 0, tag);
    good = mkSum(refSum);
    sent = att ? (bad ? good ^ 10'h004 : good) : 10'h155;
    exp  = (!att || (bad && frc)) ? good : sent;
    expErr = att && bad && !frc;
    sendWord(sent, exp, {tag, att ? (bad ? (frc ? " R8 sum" : " R9 sum") : " R7 sum") : " R6 sum"});
    check({tag, " R4 parity"}, {9'd0, exp[9] ^ exp[8]}, 10'd1);
    check({tag, expErr ? " R9 err" : " R6/R7/R8 noerr"}, {9'd0, sumErr}, {9'd0, expErr});
    // clear error so the next case starts clean (R10)
    errClear = 1; @(posedge clk); #2; errClear = 0;
    check({tag, " R10 clear"}, {9'd0, sumErr}, 10'd0);
  endtask

  task automatic testReset();
    check("R11 outValid", {9'd0, outValid}, 10'd0);
    check("R11 outWord", outWord, 10'h000);
    check("R11 sumErr", {9'd0, sumErr}, 10'd0);
  endtask

  task automatic testPassThrough();
    attachIn = 0; forceFix = 1;
    sendWord(10'h123, 10'h123, "R2 plain");
    sendWord(10'h200, 10'h200, "R2 plain");
    idle("R1");
    // broken flag then words that would be the checksum slot: untouched
    sendWord(10'h000, 10'h000, "R3 broken");
    sendWord(10'h3FF, 10'h3FF, "R3 broken");
    sendWord(10'h100, 10'h100, "R3 broken");
    for (int k = 0; k < 5; k++) sendWord(10'h0A0 + 10'(k), 10'h0A0 + 10'(k), "R3 no packet");
  endtask

  task automatic testFourModes();
    for (int m = 0; m < 4; m++) begin
      packetCase(1'b1, m[0], m[1], m, $sformatf("mode%0d attach", m));
      packetCase(1'b0, m[0], m[1], m + 4, $sformatf("mode%0d gen", m));
    end
  endtask

  task automatic testZeroCountAndHighBits();
    logic [9:0] good;
    attachIn = 0; forceFix = 0;
    // repeated 000h before the flag still detects (R3); count 0 (R5)
    sendWord(10'h000, 10'h000, "R3 extra zero");
    sendFlag("R3 flag");
    sendBody(10'h1F0, 10'h300, 9, 0, "R5 zero");
    good = mkSum(refSum);
    sendWord(10'h155, good, "R5 zero-count sum slot");
    // count word 0x202: bits 9:8 ignored, 2 udw (R5), with gaps (R12)
    sendFlag("R3 flag");
    sendBody(10'h0E1, 10'h202, 11, 1, "R5 high");
    good = mkSum(refSum);
    sendWord(10'h155, good, "R5 high-bit count sum slot");
    sendWord(10'h155, 10'h155, "R2 after packet");
  endtask

  task automatic testStickyPriority();
    logic [9:0] good;
    attachIn = 1; forceFix = 0;
    sendFlag("R3 flag");
    sendBody(10'h061, 10'd2, 3, 0, "R10");
    good = mkSum(refSum);
    sendWord(good ^ 10'h001, good ^ 10'h001, "R9 bad sum");
    repeat (3) idle("R10 hold");
    check("R10 sticky", {9'd0, sumErr}, 10'd1);
    errClear = 1; @(posedge clk); #2; errClear = 0;
    check("R10 cleared", {9'd0, sumErr}, 10'd0);
    // error and clear together: error wins
    sendFlag("R3 flag");
    sendBody(10'h062, 10'd1, 4, 0, "R10");
    good = mkSum(refSum);
    errClear = 1;
    sendWord(good ^ 10'h010, good ^ 10'h010, "R9 bad sum");
    errClear = 0;
    check("R10 set wins", {9'd0, sumErr}, 10'd1);
    rstN = 0; @(posedge clk); #2; rstN = 1;
    check("R10 reset clears", {9'd0, sumErr}, 10'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2; rstN = 1;
    testReset();
    testPassThrough();
    testFourModes();
    testZeroCountAndHighBits();
    testStickyPriority();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule